// File: doc/BRIEF.md
# Double-Trap-Aware Trap Sequencer

This block is the trap entry and trap return control of a processor core with machine, supervisor and user privilege levels. It holds the current privilege, the trap status bits and the trap registers of both the machine and supervisor levels. On a trap request it writes the cause, exception PC and trap value of the level that delegation chose. On an M-return or S-return it restores the privilege and the interrupt-enable bits.

Each level has a trap-guard bit, which trap entry sets and trap return clears. A second trap that arrives while a handler still has its guard set is a double trap. A supervisor double trap, gated by a run-time enable, is raised to machine level with a dedicated cause code, and the original cause is preserved in a second trap-value register. A machine double trap updates no register. Instead it raises a critical-error output, which stays high until reset and freezes the sequencer. Two elaboration parameters enable the machine and supervisor guard features. With both off, the block is a plain trap sequencer.

Top module: `dtrap_seq`

## Requirements
- R1: After reset the privilege is M (encoding U=0, S=1, M=3) and all trap registers, the delegation register and the critical-error output are 0. The status word (bit 0 M int-enable, 1 S int-enable, 2 M prior-enable, 3 S prior-enable, 4 S prior-privilege, 6:5 M prior-privilege, 7 S guard, 8 M guard) is 0, except bit 8, which equals the M guard feature enable.
- R2: A trap targeting M while the M guard is 0 writes the M cause (bit XLEN-1 = interrupt flag, low bits = code), the M exception PC and the M trap value. It copies M int-enable into M prior-enable, clears M int-enable, stores the current privilege in M prior-privilege, sets the M guard when that feature is enabled, and moves to privilege M, all on one clock edge.
- R3: A trap targeting S that is not redirected writes the S cause, PC and value registers. It copies S int-enable into S prior-enable, clears S int-enable, sets S prior-privilege to 1 unless the current privilege is U, sets the S guard when the feature is enabled and the double-trap enable input is 1, and moves to privilege S.
- R4: A trap targeting S while the S guard is 1 and the double-trap enable is 1 is taken as an M trap by R2. The M second trap-value register receives the original cause word, and the M cause becomes 16 with the interrupt bit 0.
- R5: A trap targeting M while the M guard is 1 changes no register and raises the critical-error output on the next edge. The output then holds until reset, and every later request is ignored.
- R6: M-return sets the privilege from M prior-privilege, copies M prior-enable into M int-enable, sets M prior-enable, sets M prior-privilege to U and clears the M guard. It clears the S guard only when the privilege returned to is U.
- R7: S-return sets the privilege from S prior-privilege, copies S prior-enable into S int-enable, sets S prior-enable, clears S prior-privilege and clears both guards.
- R8: A status write sets the two int-enables and the two guards, with a guard forced to 0 when its feature is disabled. A guard written as 1 forces its level's int-enable to 0.
- R9: The delegation register reads bit 16 (double trap) and bit 11 (M environment call) as 0 whatever is written.
- R10: With the double-trap enable input 0, an S-targeted trap is taken at S even when the S guard is 1, and that guard keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_intr | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Trap cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_val | input | XLEN | Trap value |
| trap_target | input | 2 | Privilege chosen by delegation (1 = S, other = M) |
| mret_req | input | 1 | M-return request |
| sret_req | input | 1 | S-return request |
| dbl_trap_en | input | 1 | Supervisor double-trap enable |
| stat_we | input | 1 | Status write strobe |
| stat_mie | input | 1 | Written M int-enable |
| stat_sie | input | 1 | Written S int-enable |
| stat_mdt | input | 1 | Written M guard |
| stat_sdt | input | 1 | Written S guard |
| deleg_we | input | 1 | Delegation register write strobe |
| deleg_wdata | input | XLEN | Delegation register write data |
| priv_o | output | 2 | Current privilege |
| status_o | output | 9 | Status word |
| mcause_o | output | XLEN | M cause |
| mepc_o | output | XLEN | M exception PC |
| mtval_o | output | XLEN | M trap value |
| mtval2_o | output | XLEN | M second trap value |
| scause_o | output | XLEN | S cause |
| sepc_o | output | XLEN | S exception PC |
| stval_o | output | XLEN | S trap value |
| deleg_o | output | XLEN | Delegation register |
| crit_err_o | output | 1 | Critical error, held until reset |

## Verification
The hardest state to reach is the redirected supervisor double trap. It needs the S guard set through a real S trap entry with the enable high, while the core is still at S. A second S-targeted trap must then follow with no S-return in between. The stimulus builds this from reset: it clears the M guard with a status write, returns to U, and takes an S trap. It then takes a second S trap, and later a machine double trap, which reaches the critical state only after an M trap has set the M guard again.

// File: rtl/dtrap_pkg.sv
package dtrap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef struct packed {
    logic       mdt;
    logic       sdt;
    logic [1:0] mpp;
    logic       spp;
    logic       spie;
    logic       mpie;
    logic       sie;
    logic       mie;
  } stat_t;

  typedef enum logic [2:0] {
    RT_NONE,
    RT_M_NORMAL,
    RT_M_DOUBLE,
    RT_S,
    RT_HALT
  } route_e;

endpackage

// File: rtl/dtrap_rst_sync.sv
module dtrap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dtrap_route.sv
module dtrap_route
  import dtrap_pkg::*;
#(
  parameter bit M_DBL_EN = 1'b1,
  parameter bit S_DBL_EN = 1'b1
) (
  input  logic   req,
  input  logic   halted,
  input  logic   to_sup,
  input  logic   mdt,
  input  logic   sdt,
  input  logic   dte,
  output route_e route
);
  always_comb begin
    route = RT_NONE;
    if (req && !halted) begin
      if (to_sup) begin
        if (S_DBL_EN && sdt && dte) route = RT_M_DOUBLE;
        else                        route = RT_S;
      end else begin
        if (M_DBL_EN && mdt) route = RT_HALT;
        else                 route = RT_M_NORMAL;
      end
    end
  end
endmodule

// File: rtl/dtrap_status_next.sv
module dtrap_status_next
  import dtrap_pkg::*;
#(
  parameter bit M_DBL_EN = 1'b1,
  parameter bit S_DBL_EN = 1'b1
) (
  input  priv_e  priv_q,
  input  stat_t  stat_q,
  input  route_e route,
  input  logic   do_mret,
  input  logic   do_sret,
  input  logic   do_wr,
  input  logic   wr_mie,
  input  logic   wr_sie,
  input  logic   wr_mdt,
  input  logic   wr_sdt,
  input  logic   dte,
  output priv_e  priv_d,
  output stat_t  stat_d,
  output logic   upd
);
  logic new_mdt, new_sdt;

  assign new_mdt = wr_mdt & M_DBL_EN;
  assign new_sdt = wr_sdt & S_DBL_EN;

  always_comb begin
    priv_d = priv_q;
    stat_d = stat_q;
    upd    = 1'b1;
    if (route == RT_M_NORMAL || route == RT_M_DOUBLE) begin
      stat_d.mpie = stat_q.mie;
      stat_d.mie  = 1'b0;
      stat_d.mpp  = priv_q;
      stat_d.mdt  = M_DBL_EN;
      priv_d      = PRIV_M;
    end else if (route == RT_S) begin
      stat_d.spie = stat_q.sie;
      stat_d.sie  = 1'b0;
      stat_d.spp  = (priv_q != PRIV_U);
      if (S_DBL_EN && dte) stat_d.sdt = 1'b1;
      priv_d      = PRIV_S;
    end else if (route == RT_HALT) begin
      upd = 1'b0;
    end else if (do_mret) begin
      priv_d      = priv_e'(stat_q.mpp);
      stat_d.mie  = stat_q.mpie;
      stat_d.mpie = 1'b1;
      stat_d.mpp  = PRIV_U;
      stat_d.mdt  = 1'b0;
      if (stat_q.mpp == PRIV_U) stat_d.sdt = 1'b0;
    end else if (do_sret) begin
      priv_d      = stat_q.spp ? PRIV_S : PRIV_U;
      stat_d.sie  = stat_q.spie;
      stat_d.spie = 1'b1;
      stat_d.spp  = 1'b0;
      stat_d.sdt  = 1'b0;
      stat_d.mdt  = 1'b0;
    end else if (do_wr) begin
      stat_d.mdt = new_mdt;
      stat_d.sdt = new_sdt;
      stat_d.mie = wr_mie & ~new_mdt;
      stat_d.sie = wr_sie & ~new_sdt;
    end else begin
      upd = 1'b0;
    end
  end
endmodule

// File: rtl/dtrap_seq.sv
module dtrap_seq
  import dtrap_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 5,
  parameter bit M_DBL_EN = 1'b1,
  parameter bit S_DBL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_intr,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_val,
  input  logic [1:0]        trap_target,
  input  logic              mret_req,
  input  logic              sret_req,
  input  logic              dbl_trap_en,
  input  logic              stat_we,
  input  logic              stat_mie,
  input  logic              stat_sie,
  input  logic              stat_mdt,
  input  logic              stat_sdt,
  input  logic              deleg_we,
  input  logic [XLEN-1:0]   deleg_wdata,
  output logic [1:0]        priv_o,
  output logic [8:0]        status_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic [XLEN-1:0]   mtval2_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   deleg_o,
  output logic              crit_err_o
);
  localparam int PAD_W       = XLEN - 1 - CODE_W;
  localparam int DBL_CODE    = 16;
  localparam int MECALL_CODE = 11;
  localparam logic [XLEN-1:0] DELEG_MASK =
    ~((XLEN'(1) << DBL_CODE) | (XLEN'(1) << MECALL_CODE));
  localparam logic [XLEN-1:0] DBL_CAUSE = XLEN'(DBL_CODE);

  logic            rst_sync_n;
  priv_e           priv_q, priv_d;
  stat_t           stat_q, stat_d, stat_rst;
  logic            stat_upd;
  route_e          route;
  logic            halt_q, halt_d;
  logic            dte_eff;
  logic            m_en, s_en, dbl_en, deleg_en;
  logic [XLEN-1:0] cause_word;
  logic [XLEN-1:0] mcause_q, mepc_q, mtval_q, mtval2_q;
  logic [XLEN-1:0] scause_q, sepc_q, stval_q, deleg_q;
  logic [XLEN-1:0] mcause_d;

  dtrap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign dte_eff    = dbl_trap_en & S_DBL_EN;
  assign cause_word = {trap_intr, {PAD_W{1'b0}}, trap_code};

  dtrap_route #(.M_DBL_EN(M_DBL_EN), .S_DBL_EN(S_DBL_EN)) u_route (
    .req    (trap_req),
    .halted (halt_q),
    .to_sup (trap_target == PRIV_S),
    .mdt    (stat_q.mdt),
    .sdt    (stat_q.sdt),
    .dte    (dte_eff),
    .route  (route)
  );

  dtrap_status_next #(.M_DBL_EN(M_DBL_EN), .S_DBL_EN(S_DBL_EN)) u_stat (
    .priv_q  (priv_q),
    .stat_q  (stat_q),
    .route   (route),
    .do_mret (mret_req & ~halt_q),
    .do_sret (sret_req & ~halt_q),
    .do_wr   (stat_we & ~halt_q),
    .wr_mie  (stat_mie),
    .wr_sie  (stat_sie),
    .wr_mdt  (stat_mdt),
    .wr_sdt  (stat_sdt),
    .dte     (dte_eff),
    .priv_d  (priv_d),
    .stat_d  (stat_d),
    .upd     (stat_upd)
  );

  always_comb begin
    m_en     = (route == RT_M_NORMAL) || (route == RT_M_DOUBLE);
    dbl_en   = (route == RT_M_DOUBLE);
    s_en     = (route == RT_S);
    deleg_en = deleg_we & ~halt_q;
    mcause_d = dbl_en ? DBL_CAUSE : cause_word;
    halt_d   = halt_q | (route == RT_HALT);
    stat_rst = '0;
    stat_rst.mdt = M_DBL_EN;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      priv_q   <= PRIV_M;
      stat_q   <= stat_rst;
      halt_q   <= 1'b0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
      mtval2_q <= '0;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
      deleg_q  <= '0;
    end else begin
      if (stat_upd) begin
        priv_q <= priv_d;
        stat_q <= stat_d;
      end
      halt_q <= halt_d;
      if (m_en) begin
        mcause_q <= mcause_d;
        mepc_q   <= trap_pc;
        mtval_q  <= trap_val;
      end
      if (dbl_en) mtval2_q <= cause_word;
      if (s_en) begin
        scause_q <= cause_word;
        sepc_q   <= trap_pc;
        stval_q  <= trap_val;
      end
      if (deleg_en) deleg_q <= deleg_wdata & DELEG_MASK;
    end
  end

  assign priv_o     = priv_q;
  assign status_o   = stat_q;
  assign mcause_o   = mcause_q;
  assign mepc_o     = mepc_q;
  assign mtval_o    = mtval_q;
  assign mtval2_o   = mtval2_q;
  assign scause_o   = scause_q;
  assign sepc_o     = sepc_q;
  assign stval_o    = stval_q;
  assign deleg_o    = deleg_q;
  assign crit_err_o = halt_q;
endmodule

// File: rtl/dtrap_seq_chk.sv
module dtrap_seq_chk #(
  parameter int XLEN     = 32,
  parameter bit M_DBL_EN = 1'b1,
  parameter bit S_DBL_EN = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic [1:0]      trap_target,
  input logic [XLEN-1:0] trap_pc,
  input logic            dbl_trap_en,
  input logic [1:0]      priv_o,
  input logic [8:0]      status_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] deleg_o,
  input logic            crit_err_o
);
  // R5: critical error is sticky
  assert_crit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crit_err_o |=> crit_err_o);

  // R5: nothing moves once halted
  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crit_err_o |=> ($stable(priv_o) && $stable(status_o) && $stable(mcause_o)));

  // R4: supervisor double trap lands at M with cause 16
  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (S_DBL_EN && trap_req && trap_target == 2'b01 && status_o[7] && dbl_trap_en && !crit_err_o)
    |=> (priv_o == 2'b11 && mcause_o == XLEN'(16)));

  // R2: ordinary M trap entry
  assert_mtrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_target != 2'b01 && !status_o[8] && !crit_err_o)
    |=> (priv_o == 2'b11 && !status_o[0] && mepc_o == $past(trap_pc)
         && status_o[8] == M_DBL_EN));

  // R8: a set guard keeps its int-enable clear
  assert_mguard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[8] |-> !status_o[0]);
  assert_sguard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |-> !status_o[1]);

  // R9: double-trap cause never delegable
  always_comb begin
    if (rst_n) assert_deleg_R9: assert (!deleg_o[16]);
  end
endmodule

bind dtrap_seq dtrap_seq_chk #(
  .XLEN(XLEN), .M_DBL_EN(M_DBL_EN), .S_DBL_EN(S_DBL_EN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .trap_req    (trap_req),
  .trap_target (trap_target),
  .trap_pc     (trap_pc),
  .dbl_trap_en (dbl_trap_en),
  .priv_o      (priv_o),
  .status_o    (status_o),
  .mcause_o    (mcause_o),
  .mepc_o      (mepc_o),
  .deleg_o     (deleg_o),
  .crit_err_o  (crit_err_o)
);

// File: tb/dtrap_seq_tb.sv
module dtrap_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NV = 12;

  localparam logic [1:0] OP_TRAP = 2'd0, OP_MRET = 2'd1, OP_SRET = 2'd2, OP_WSTAT = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        intr;
    logic [4:0]  code;
    logic [1:0]  tgt;
    logic        dte;
    logic [3:0]  wr;      // {mie, sie, mdt, sdt}
    logic [1:0]  e_priv;
    logic [8:0]  e_stat;
    logic [31:0] e_mcause;
    logic [31:0] e_mtval2;
    logic [31:0] e_scause;
    logic        e_crit;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{OP_WSTAT, 1'b0, 5'd0,  2'd0, 1'b1, 4'b1100, 2'd3, 9'h003, 32'h0,        32'h0, 32'h0,        1'b0},
    '{OP_MRET,  1'b0, 5'd0,  2'd0, 1'b1, 4'b0000, 2'd0, 9'h006, 32'h0,        32'h0, 32'h0,        1'b0},
    '{OP_TRAP,  1'b0, 5'd8,  2'd1, 1'b1, 4'b0000, 2'd1, 9'h08C, 32'h0,        32'h0, 32'h8,        1'b0},
    '{OP_TRAP,  1'b0, 5'd13, 2'd1, 1'b1, 4'b0000, 2'd3, 9'h1A8, 32'h10,       32'hD, 32'h8,        1'b0},
    '{OP_MRET,  1'b0, 5'd0,  2'd0, 1'b1, 4'b0000, 2'd1, 9'h08C, 32'h10,       32'hD, 32'h8,        1'b0},
    '{OP_SRET,  1'b0, 5'd0,  2'd0, 1'b1, 4'b0000, 2'd0, 9'h00E, 32'h10,       32'hD, 32'h8,        1'b0},
    '{OP_TRAP,  1'b1, 5'd5,  2'd1, 1'b0, 4'b0000, 2'd1, 9'h00C, 32'h10,       32'hD, 32'h80000005, 1'b0},
    '{OP_WSTAT, 1'b0, 5'd0,  2'd0, 1'b0, 4'b0101, 2'd1, 9'h08C, 32'h10,       32'hD, 32'h80000005, 1'b0},
    '{OP_TRAP,  1'b0, 5'd2,  2'd1, 1'b0, 4'b0000, 2'd1, 9'h094, 32'h10,       32'hD, 32'h2,        1'b0},
    '{OP_TRAP,  1'b1, 5'd7,  2'd3, 1'b1, 4'b0000, 2'd3, 9'h1B0, 32'h80000007, 32'hD, 32'h2,        1'b0},
    '{OP_TRAP,  1'b0, 5'd3,  2'd3, 1'b1, 4'b0000, 2'd3, 9'h1B0, 32'h80000007, 32'hD, 32'h2,        1'b1},
    '{OP_MRET,  1'b0, 5'd0,  2'd0, 1'b1, 4'b0000, 2'd3, 9'h1B0, 32'h80000007, 32'hD, 32'h2,        1'b1}
  };

  logic clk, rst_n;
  logic trap_req, trap_intr, mret_req, sret_req, dbl_trap_en;
  logic [4:0] trap_code;
  logic [XLEN-1:0] trap_pc, trap_val, deleg_wdata;
  logic [1:0] trap_target;
  logic stat_we, stat_mie, stat_sie, stat_mdt, stat_sdt, deleg_we;
  logic [1:0] priv_o;
  logic [8:0] status_o;
  logic [XLEN-1:0] mcause_o, mepc_o, mtval_o, mtval2_o, scause_o, sepc_o, stval_o, deleg_o;
  logic crit_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  dtrap_seq #(.XLEN(XLEN), .CODE_W(5), .M_DBL_EN(1'b1), .S_DBL_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_intr(trap_intr),
    .trap_code(trap_code), .trap_pc(trap_pc), .trap_val(trap_val),
    .trap_target(trap_target), .mret_req(mret_req), .sret_req(sret_req),
    .dbl_trap_en(dbl_trap_en), .stat_we(stat_we), .stat_mie(stat_mie),
    .stat_sie(stat_sie), .stat_mdt(stat_mdt), .stat_sdt(stat_sdt),
    .deleg_we(deleg_we), .deleg_wdata(deleg_wdata), .priv_o(priv_o),
    .status_o(status_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o),
    .mtval2_o(mtval2_o), .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
    .deleg_o(deleg_o), .crit_err_o(crit_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    trap_req = 0; trap_intr = 0; trap_code = '0; trap_pc = '0; trap_val = '0;
    trap_target = 2'd3; mret_req = 0; sret_req = 0; stat_we = 0;
    stat_mie = 0; stat_sie = 0; stat_mdt = 0; stat_sdt = 0;
    deleg_we = 0; deleg_wdata = '0;
  endtask

  function automatic string tag_of(int i);
    case (i)
      0, 7:   return "R8";
      1, 4:   return "R6";
      2, 6:   return "R3";
      3:      return "R4";
      5:      return "R7";
      8:      return "R10";
      9:      return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    dbl_trap_en = 1'b1;
    do_reset();
    // R1: reset state
    chk("R1 priv", 32'(priv_o), 32'd3);
    chk("R1 status", 32'(status_o), 32'h100);
    chk("R1 mcause", mcause_o, 32'h0);
    chk("R1 crit", 32'(crit_err_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      dbl_trap_en = TBL[i].dte;
      case (TBL[i].op)
        OP_TRAP: begin
          trap_req = 1; trap_intr = TBL[i].intr; trap_code = TBL[i].code;
          trap_target = TBL[i].tgt; trap_pc = 32'h1000 + 32'(i) * 4;
          trap_val = 32'hA0 + 32'(i);
        end
        OP_MRET: mret_req = 1;
        OP_SRET: sret_req = 1;
        default: begin
          stat_we = 1; {stat_mie, stat_sie, stat_mdt, stat_sdt} = TBL[i].wr;
        end
      endcase
      @(negedge clk);
      idle_inputs();
      chk({tag_of(i), " priv"},   32'(priv_o),   32'(TBL[i].e_priv));
      chk({tag_of(i), " status"}, 32'(status_o), 32'(TBL[i].e_stat));
      chk({tag_of(i), " mcause"}, mcause_o,      TBL[i].e_mcause);
      chk({tag_of(i), " mtval2"}, mtval2_o,      TBL[i].e_mtval2);
      chk({tag_of(i), " scause"}, scause_o,      TBL[i].e_scause);
      chk({tag_of(i), " crit"},   32'(crit_err_o), 32'(TBL[i].e_crit));
    end

    // R2: last M entry was row 9; halted row 10 wrote nothing (R5)
    chk("R2 mepc", mepc_o, 32'h1024);
    chk("R5 mtval untouched", mtval_o, 32'hA9);
    // R3: last S entry was row 8
    chk("R3 sepc", sepc_o, 32'h1020);
    chk("R3 stval", stval_o, 32'hA8);

    // R1: reset clears critical state
    do_reset();
    chk("R1 priv after halt", 32'(priv_o), 32'd3);
    chk("R1 status after halt", 32'(status_o), 32'h100);
    chk("R1 crit after halt", 32'(crit_err_o), 32'h0);
    chk("R1 mtval2", mtval2_o, 32'h0);
    chk("R1 deleg", deleg_o, 32'h0);

    // R9: delegation register masks bits 16 and 11
    deleg_we = 1; deleg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    idle_inputs();
    chk("R9 deleg", deleg_o, 32'hFFFE_F7FF);

    // R8: M guard written with M int-enable forces int-enable 0
    stat_we = 1; {stat_mie, stat_sie, stat_mdt, stat_sdt} = 4'b1110;
    @(negedge clk);
    idle_inputs();
    chk("R8 guard forces mie", 32'(status_o), 32'h102);

    // R5: M trap with M guard set halts at once
    trap_req = 1; trap_target = 2'd3; trap_code = 5'd4; trap_pc = 32'h77;
    @(negedge clk);
    idle_inputs();
    chk("R5 crit", 32'(crit_err_o), 32'h1);
    chk("R5 mepc kept", mepc_o, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule